// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Capture Strobe

This block presents a five-decade BCD result one decade at a time. It drives five positive-going digit-select lines and a shared 4-bit BCD bus, so an external display can be scanned from few pins. Each new result is announced with `res_valid`, which loads the value and an overrange flag. The scan then starts at the most significant decade, steps down to the least significant one, and wraps back to repeat for as long as no new result arrives.

On the first pass after each new result, an active-low strobe pulses for half a clock near the middle of every digit slot. An external latch, processor or serial transmitter can use that pulse to capture the five decades. Later passes over the same value carry no strobe. The MSD slot is one clock longer than the other slots.

When a result is flagged as overrange, the bus carries zeros for the whole time. All digit lines go dark right after the last strobe of the first pass, and they stay dark until the next result arrives. Because results arrive steadily, the display blinks. The block has no back-pressure: `res_valid` is a one-cycle valid with no ready, and every pulse is accepted, even in the middle of a scan.

Top module: `bcd_digit_scanner`

## Requirements
- R1: At most one digit line is high at a time. `dig_o[4]` selects the MSD (`res_bcd[19:16]`) and `dig_o[0]` selects the LSD (`res_bcd[3:0]`). The scan goes from `dig_o[4]` down to `dig_o[0]` and then starts again at `dig_o[4]`.
- R2: `dig_o[4]` stays high for 201 consecutive clocks in each pass. Each of `dig_o[3]` to `dig_o[0]` stays high for 200 clocks.
- R3: While `dig_o[k]` is high and the result is not overrange, `bcd_o` equals `res_bcd[4k+3:4k]` of the latched result, true-high. `bcd_o` changes on the same clock edge as the digit line.
- R4: Number the clocks of a slot from 0, with clock 0 being the first clock after the digit line rises. `strobe_n` is low only during the second half of slot clock 101 of the MSD slot, or of slot clock 100 of the other slots. It is high at every rising edge.
- R5: Each accepted result gives exactly five strobe pulses, all in the first pass. Later passes give none.
- R6: While the latched result is overrange, `bcd_o` is 0.
- R7: For an overrange result, the first pass runs up to the LSD strobe. On the next edge all digit lines go low, so `dig_o[0]` is high for 101 clocks. The lines then stay low until the next `res_valid`.
- R8: A `res_valid` during a scan restarts at the MSD slot at clock 0. It loads the new value and flag, and the strobe is enabled again.
- R9: After reset, and until the first `res_valid`, `dig_o` and `bcd_o` are 0 and `strobe_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the strobe uses both of its edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle valid for a new result; always accepted |
| res_bcd | input | 20 | Five BCD decades, MSD in bits 19:16 |
| res_ovr | input | 1 | Overrange flag that goes with the result |
| dig_o | output | 5 | Digit-select lines, bit 4 = MSD |
| bcd_o | output | 4 | BCD value of the selected decade |
| strobe_n | output | 1 | Active-low half-clock capture strobe |

## Verification
A result with five distinct nonzero decades shows whether the decade order, the bus-to-digit pairing and the 201/200 slot widths are right. A second pass over the same result shows that the strobe stays quiet after the first pass. A second result sent 450 clocks into a scan must start over at the MSD with five fresh strobes, which separates a restart from a slot that merely finishes. An overrange result, followed by a long idle stretch and then a normal result, shows the blanking of the bus and digits and the return of scanning. All-zero and alternating-zero values check that a zero decade is still selected and strobed.

// File: rtl/bcdscan_pkg.sv
package bcdscan_pkg;
  localparam int DEF_DIGITS    = 5;
  localparam int DEF_SLOT_LEN  = 200;
  localparam int DEF_MSD_EXTRA = 1;
  localparam int DEF_STROBE_AT = 100;
  localparam int NIB_W         = 4;
endpackage

// File: rtl/bcdscan_timer.sv
module bcdscan_timer #(
  parameter int NUM_DIGITS = bcdscan_pkg::DEF_DIGITS,
  parameter int SLOT_LEN   = bcdscan_pkg::DEF_SLOT_LEN,
  parameter int MSD_EXTRA  = bcdscan_pkg::DEF_MSD_EXTRA,
  parameter int STROBE_AT  = bcdscan_pkg::DEF_STROBE_AT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  ovr_in,
  output logic [NUM_DIGITS-1:0] dig_q,
  output logic [NUM_DIGITS-1:0] dig_nxt,
  output logic                  ovr_q,
  output logic                  ovr_nxt,
  output logic                  strb_nxt
);
  localparam int MSD_LEN = SLOT_LEN + MSD_EXTRA;
  localparam int CNT_W   = $clog2(MSD_LEN + 1);
  localparam logic [CNT_W-1:0] MSD_LAST = CNT_W'(MSD_LEN - 1);
  localparam logic [CNT_W-1:0] OTH_LAST = CNT_W'(SLOT_LEN - 1);
  localparam logic [CNT_W-1:0] MSD_MID  = CNT_W'(STROBE_AT + MSD_EXTRA);
  localparam logic [CNT_W-1:0] OTH_MID  = CNT_W'(STROBE_AT);
  localparam logic [NUM_DIGITS-1:0] MSD_HOT = {1'b1, {(NUM_DIGITS-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q, cnt_nxt, last_now, mid_now;
  logic             armed_q, armed_nxt, is_msd, is_lsd, scanning;

  assign is_msd   = dig_q[NUM_DIGITS-1];
  assign is_lsd   = dig_q[0];
  assign scanning = |dig_q;
  assign last_now = is_msd ? MSD_LAST : OTH_LAST;
  assign mid_now  = is_msd ? MSD_MID : OTH_MID;

  always_comb begin
    dig_nxt   = dig_q;
    cnt_nxt   = cnt_q;
    armed_nxt = armed_q;
    ovr_nxt   = ovr_q;
    if (start) begin
      dig_nxt   = MSD_HOT;
      cnt_nxt   = '0;
      armed_nxt = 1'b1;
      ovr_nxt   = ovr_in;
    end else if (scanning) begin
      if (ovr_q && is_lsd && cnt_q == mid_now) begin
        dig_nxt   = '0;
        cnt_nxt   = '0;
        armed_nxt = 1'b0;
      end else if (cnt_q == last_now) begin
        cnt_nxt = '0;
        if (is_lsd) begin
          dig_nxt   = MSD_HOT;
          armed_nxt = 1'b0;
        end else begin
          dig_nxt = dig_q >> 1;
        end
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  assign strb_nxt = armed_nxt && (|dig_nxt) &&
                    (cnt_nxt == (dig_nxt[NUM_DIGITS-1] ? MSD_MID : OTH_MID));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      dig_q   <= dig_nxt;
      cnt_q   <= cnt_nxt;
      armed_q <= armed_nxt;
      ovr_q   <= ovr_nxt;
    end
  end

  assert_digit_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_q));

  assert_msd_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_msd && cnt_q == MSD_LAST && !start) |=> dig_q[NUM_DIGITS-2]);

  assert_ovr_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && is_lsd && cnt_q == OTH_MID && !start) |=> (dig_q == '0));
endmodule

// File: rtl/bcdscan_datapath.sv
module bcdscan_datapath #(
  parameter int NUM_DIGITS = bcdscan_pkg::DEF_DIGITS,
  localparam int NW        = bcdscan_pkg::NIB_W,
  localparam int VAL_W     = NUM_DIGITS * NW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [VAL_W-1:0]      val_in,
  input  logic [NUM_DIGITS-1:0] dig_nxt,
  input  logic                  ovr_nxt,
  output logic [NW-1:0]         bcd_q
);
  logic [VAL_W-1:0] val_q, src;
  logic [NW-1:0]    pick;

  assign src = start ? val_in : val_q;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (dig_nxt[i]) pick = pick | src[i*NW +: NW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      bcd_q <= '0;
    end else begin
      if (start) val_q <= val_in;
      bcd_q <= ovr_nxt ? '0 : pick;
    end
  end

  assert_idle_bus_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dig_nxt) == '0) |-> (bcd_q == '0));
endmodule

// File: rtl/bcdscan_strobe.sv
module bcdscan_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_nxt,
  output logic strobe_n
);
  logic cyc_q, half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= 1'b0;
    else        cyc_q <= strb_nxt;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= cyc_q;
  end

  assign strobe_n = ~(cyc_q & half_q);

  assert_strobe_high_at_fall_R4: assert property (@(negedge clk) disable iff (!rst_n)
    strobe_n);
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner #(
  parameter int NUM_DIGITS = bcdscan_pkg::DEF_DIGITS,
  parameter int SLOT_LEN   = bcdscan_pkg::DEF_SLOT_LEN,
  parameter int MSD_EXTRA  = bcdscan_pkg::DEF_MSD_EXTRA,
  parameter int STROBE_AT  = bcdscan_pkg::DEF_STROBE_AT,
  localparam int NW        = bcdscan_pkg::NIB_W,
  localparam int VAL_W     = NUM_DIGITS * NW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  res_valid,
  input  logic [VAL_W-1:0]      res_bcd,
  input  logic                  res_ovr,
  output logic [NUM_DIGITS-1:0] dig_o,
  output logic [NW-1:0]         bcd_o,
  output logic                  strobe_n
);
  logic [NUM_DIGITS-1:0] dig_nxt;
  logic                  ovr_q, ovr_nxt, strb_nxt;

  bcdscan_timer #(
    .NUM_DIGITS(NUM_DIGITS), .SLOT_LEN(SLOT_LEN),
    .MSD_EXTRA(MSD_EXTRA), .STROBE_AT(STROBE_AT)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(res_valid), .ovr_in(res_ovr),
    .dig_q(dig_o), .dig_nxt(dig_nxt), .ovr_q(ovr_q), .ovr_nxt(ovr_nxt),
    .strb_nxt(strb_nxt)
  );

  bcdscan_datapath #(.NUM_DIGITS(NUM_DIGITS)) u_data (
    .clk(clk), .rst_n(rst_n), .start(res_valid), .val_in(res_bcd),
    .dig_nxt(dig_nxt), .ovr_nxt(ovr_nxt), .bcd_q(bcd_o)
  );

  bcdscan_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .strb_nxt(strb_nxt), .strobe_n(strobe_n)
  );

  assert_ovr_bus_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> (bcd_o == '0));
endmodule

// File: tb/tb_bcd_digit_scanner.sv
module tb_bcd_digit_scanner;
  localparam int CLK_PERIOD = 8;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [19:0] res_bcd = '0;
  logic        res_ovr = 1'b0;
  logic [4:0]  dig_o;
  logic [3:0]  bcd_o;
  logic        strobe_n;

  bcd_digit_scanner dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_bcd(res_bcd),
    .res_ovr(res_ovr), .dig_o(dig_o), .bcd_o(bcd_o), .strobe_n(strobe_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit m_on = 0, m_armed = 0, m_ovr = 0;
  int m_pos = 0, m_cnt = 0;
  logic [19:0] m_val = '0;

  // observation counters
  int strobes = 0, bus_nz = 0;
  int hi_cnt [5];

  function automatic int slot_len(int p); return (p == 0) ? 201 : 200; endfunction
  function automatic int slot_mid(int p); return (p == 0) ? 101 : 100; endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_obs();
    strobes = 0; bus_nz = 0;
    for (int i = 0; i < 5; i++) hi_cnt[i] = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  // model and per-cycle comparison
  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        m_on = 0; m_armed = 0; m_ovr = 0; m_pos = 0; m_cnt = 0; m_val = '0;
      end else if (res_valid) begin
        m_on = 1; m_pos = 0; m_cnt = 0; m_armed = 1; m_ovr = res_ovr; m_val = res_bcd;
      end else if (m_on) begin
        if (m_ovr && m_pos == 4 && m_cnt == slot_mid(4)) begin
          m_on = 0; m_armed = 0; m_cnt = 0;
        end else if (m_cnt == slot_len(m_pos) - 1) begin
          m_cnt = 0;
          if (m_pos == 4) begin m_pos = 0; m_armed = 0; end
          else m_pos++;
        end else m_cnt++;
      end
      #(CLK_PERIOD/4);
      begin
        logic [4:0] e_dig;
        logic [3:0] e_bcd;
        e_dig = m_on ? 5'(1 << (4 - m_pos)) : 5'd0;
        e_bcd = (m_on && !m_ovr) ? 4'((m_val >> ((4 - m_pos) * 4)) & 20'hF) : 4'd0;
        check(dig_o === e_dig, "R1 R2", "digit lines", dig_o, e_dig);
        check(bcd_o === e_bcd, m_ovr ? "R6" : "R3", "bcd bus", bcd_o, e_bcd);
        check(strobe_n === 1'b1, "R4", "strobe in first half", strobe_n, 1);
        for (int i = 0; i < 5; i++) if (dig_o[i] === 1'b1) hi_cnt[i]++;
        if (bcd_o !== 4'd0) bus_nz++;
      end
      #(CLK_PERIOD/2);
      begin
        bit e_low;
        e_low = m_on && m_armed && (m_cnt == slot_mid(m_pos));
        check(strobe_n === ~e_low, "R4", "strobe in second half", strobe_n, ~e_low);
        if (strobe_n === 1'b0) strobes++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/8);
  endtask

  task automatic send(logic [19:0] v, bit ovr);
    res_bcd = v; res_ovr = ovr; res_valid = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/8);
    res_valid = 1'b0;
    clear_obs();
  endtask

  initial begin
    wait_cyc(3);
    check(dig_o === 5'd0, "R9", "reset digits", dig_o, 0);
    check(bcd_o === 4'd0, "R9", "reset bus", bcd_o, 0);
    check(strobe_n === 1'b1, "R9", "reset strobe", strobe_n, 1);
    rst_n = 1'b1;
    clear_obs();
    wait_cyc(30);
    check(hi_cnt[4] + hi_cnt[0] + strobes == 0, "R9", "idle before first result", hi_cnt[4] + strobes, 0);

    // distinct decades: order, widths, five strobes
    send(20'h12345, 0);
    wait_cyc(1001);
    check(hi_cnt[4] == 201, "R2", "MSD width", hi_cnt[4], 201);
    check(hi_cnt[3] == 200, "R2", "D4 width", hi_cnt[3], 200);
    check(hi_cnt[0] == 200, "R2", "LSD width", hi_cnt[0], 200);
    check(strobes == 5, "R5", "strobes first pass", strobes, 5);
    clear_obs();
    wait_cyc(1001);
    check(strobes == 0, "R5", "strobes second pass", strobes, 0);
    check(hi_cnt[4] == 201, "R1", "scan repeats", hi_cnt[4], 201);

    // restart mid-scan
    send(20'h98765, 0);
    wait_cyc(450);
    send(20'h40302, 0);
    wait_cyc(1001);
    check(strobes == 5, "R8", "strobes after restart", strobes, 5);
    check(hi_cnt[4] == 201, "R8", "restart at MSD", hi_cnt[4], 201);

    // overrange: blank bus, dark after last strobe
    send(20'h99999, 1);
    wait_cyc(1001);
    check(strobes == 5, "R7", "overrange strobes", strobes, 5);
    check(hi_cnt[0] == 101, "R7", "LSD lit until strobe", hi_cnt[0], 101);
    check(bus_nz == 0, "R6", "overrange bus zero", bus_nz, 0);
    clear_obs();
    wait_cyc(2000);
    check(hi_cnt[4] + hi_cnt[2] + hi_cnt[0] == 0, "R7", "dark until next result",
          hi_cnt[4] + hi_cnt[2] + hi_cnt[0], 0);
    check(strobes == 0, "R7", "no strobe while dark", strobes, 0);

    // resume with zero decades
    send(20'h00000, 0);
    wait_cyc(1001);
    check(strobes == 5, "R5", "zero value strobes", strobes, 5);
    check(hi_cnt[1] == 200, "R1", "zero value D2 lit", hi_cnt[1], 200);
    send(20'h09090, 0);
    wait_cyc(2002);
    check(strobes == 5, "R3", "alternating value strobes", strobes, 5);
    finish_run();
  end
endmodule